// File: doc/BRIEF.md
# Single-Word DMA Slave Handshake Port

This block sits between a byte-wide endpoint FIFO and an external DMA master. It acts as the slave side of a request/strobe handshake and moves exactly one byte per request. When the endpoint is an IN endpoint, the master writes bytes into the FIFO. When it is an OUT endpoint, the master reads bytes out of the FIFO. The request is raised only when the FIFO can take or supply a byte. It is dropped as soon as a byte completes, and it is raised again only if more room or data is still there.

Software starts a transfer with a Go pulse and can end it at any moment with a Stop pulse. A byte-count mode can also end the transfer by itself once a preset number of bytes has moved. A programmable hold-off can keep the request low after every fourth byte. The hold-off is a count of fixed time units, and each unit is a parameterised number of clock cycles. The strobes arrive already synchronised to the clock. A polarity bit chooses which edge of the strobe completes a byte.

Top module: `swdma_port`

## Requirements
- R1: While reset is high and after reset, `dma_req`, `xfer_running`, `xfer_done` and `dma_dout_en` are 0 and `dma_req_n` is 1.
- R2: A Go pulse starts a transfer only when `cfg_single` is 1. With `cfg_single` at 0 the block stays idle and never requests.
- R3: `dma_req` is 1 only while a transfer runs and the FIFO can serve the chosen path. `cfg_dir_in`=1 selects the write path, which needs `fifo_full`=0. `cfg_dir_in`=0 selects the read path, which needs `fifo_empty`=0. `dma_req_n` is always the inverse of `dma_req`.
- R4: A byte completes on the activating edge of the path's strobe, which is `dma_wr_strb` on the write path and `dma_rd_strb` on the read path. With `cfg_strobe_hi`=1 the activating edge is 0→1; with 0 it is 1→0. On the write path `fifo_push` pulses for that one cycle with `fifo_wdata`=`dma_din`. On the read path `fifo_pop` pulses for that one cycle.
- R5: After a completed byte, `dma_req` is 0 in the next cycle. If room or data remains and no hold-off applies, it returns to 1 exactly one cycle later.
- R6: `dma_dout_en` is 1 only when a read-path transfer runs and `dma_ack` is 1. `dma_dout` carries `fifo_rdata`.
- R7: When `cfg_gap_units` N is nonzero, the request stays low after each fourth byte of a transfer, counted from Go, for N×UNIT_CYCLES cycles on top of the normal one-cycle drop. When N is 0 no extra gap is added.
- R8: When `cfg_count_en` is 1 at Go, `cfg_count` bytes are transferred. After the last one, `xfer_running` falls and `xfer_done` rises. A count of 0 finishes at Go with no byte moved.
- R9: A Stop pulse clears `xfer_running` and `dma_req` and sets `xfer_done` at the next edge. A strobe edge in the same cycle as Stop is discarded: no push and no pop.
- R10: A Go that starts a transfer clears `xfer_done`.
- R11: A strobe edge while `dma_req` is 0 has no effect on the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_single | input | 1 | Single-word mode enable |
| cfg_dir_in | input | 1 | 1: write path (IN endpoint), 0: read path (OUT endpoint) |
| cfg_strobe_hi | input | 1 | Strobe polarity, 1 = active high |
| cfg_gap_units | input | GAP_W | Hold-off length in time units after each fourth byte |
| cfg_count_en | input | 1 | Byte-count mode enable |
| cfg_count | input | CNT_W | Bytes to transfer in count mode |
| ctl_go | input | 1 | Start pulse |
| ctl_stop | input | 1 | Forced-stop pulse |
| fifo_full | input | 1 | FIFO has no room |
| fifo_empty | input | 1 | FIFO holds no data |
| fifo_rdata | input | DATA_W | FIFO head byte |
| fifo_push | output | 1 | Write one byte into the FIFO |
| fifo_pop | output | 1 | Remove the FIFO head byte |
| fifo_wdata | output | DATA_W | Byte to write |
| dma_ack | input | 1 | Master acknowledge, enables read data |
| dma_wr_strb | input | 1 | Master write strobe |
| dma_rd_strb | input | 1 | Master read strobe |
| dma_din | input | DATA_W | Write data from master |
| dma_dout | output | DATA_W | Read data to master |
| dma_dout_en | output | 1 | Read data valid/drive enable |
| dma_req | output | 1 | Transfer request |
| dma_req_n | output | 1 | Inverted transfer request |
| xfer_running | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Transfer finished by count or stop |

## Verification
A forced stop and a master strobe can land in the same clock cycle. In that case the stop must win and the byte must vanish without touching the FIFO. The bench provokes this by waiting until the request is high. It then raises `ctl_stop` and the write strobe on the same falling clock edge. After the next edge it checks three things: the FIFO push count has not moved, `xfer_done` is set, and the request is down. The byte that completes a count-mode transfer is a second case of two events in one cycle. That byte must be pushed while the transfer ends at the same edge, and this is judged from the push count together with `xfer_running` and `xfer_done`.

// File: rtl/swdma_pkg.sv
package swdma_pkg;

    localparam int GROUP_BYTES = 4;

    typedef enum logic {
        PATH_READ  = 1'b0,
        PATH_WRITE = 1'b1
    } path_e;

    typedef struct packed {
        logic  single;
        path_e path;
        logic  strobe_hi;
        logic  count_en;
    } port_cfg_t;

    // Active level of a strobe for the selected polarity.
    function automatic logic strobe_active(input logic raw, input logic hi);
        return hi ? raw : ~raw;
    endfunction

    // FIFO can serve one more byte on the given path.
    function automatic logic fifo_can_serve(input path_e p, input logic full, input logic empty);
        return (p == PATH_WRITE) ? ~full : ~empty;
    endfunction

endpackage

// File: rtl/swdma_strobe_edge.sv
module swdma_strobe_edge
    import swdma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic hi,
    output logic fire
);
    logic act;
    logic act_prev;

    assign act  = strobe_active(raw, hi);
    assign fire = act & ~act_prev;

    // Reset to "active" so a strobe already asserted at reset release is not an edge.
    always_ff @(posedge clk) begin
        if (rst) act_prev <= 1'b1;
        else     act_prev <= act;
    end
endmodule

// File: rtl/swdma_gap_timer.sv
module swdma_gap_timer
    import swdma_pkg::*;
#(
    parameter int UNIT_CYCLES = 4,
    parameter int GAP_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             byte_done,
    input  logic [GAP_W-1:0] gap_units,
    output logic             hold
);
    localparam int GRP_W   = $clog2(GROUP_BYTES);
    localparam int PRESC_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [GRP_W-1:0]   GRP_LAST = GRP_W'(GROUP_BYTES - 1);
    localparam logic [PRESC_W-1:0] PRESC_TOP = PRESC_W'(UNIT_CYCLES - 1);

    logic [GRP_W-1:0]   grp_q;
    logic [PRESC_W-1:0] presc_q;
    logic [GAP_W-1:0]   units_q;

    assign hold = (units_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            grp_q   <= '0;
            presc_q <= '0;
            units_q <= '0;
        end else if (byte_done) begin
            grp_q <= grp_q + 1'b1;
            if (grp_q == GRP_LAST && gap_units != '0) begin
                units_q <= gap_units;
                presc_q <= PRESC_TOP;
            end
        end else if (units_q != '0) begin
            if (presc_q == '0) begin
                units_q <= units_q - 1'b1;
                presc_q <= PRESC_TOP;
            end else begin
                presc_q <= presc_q - 1'b1;
            end
        end
    end

    // R7: no byte can complete while the hold-off runs (the request is low)
    assert_no_byte_in_gap_R7: assert property (@(posedge clk) disable iff (rst)
        hold |-> !byte_done);
endmodule

// File: rtl/swdma_byte_counter.sv
module swdma_byte_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] remain_q;

    assign last = (remain_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)       remain_q <= '0;
        else if (load) remain_q <= load_val;
        else if (dec)  remain_q <= remain_q - 1'b1;
    end

    // R8: the control side never counts a byte past zero
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        dec |-> remain_q != '0);
endmodule

// File: rtl/swdma_port.sv
module swdma_port
    import swdma_pkg::*;
#(
    parameter int UNIT_CYCLES = 4,
    parameter int GAP_W       = 4,
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_single,
    input  logic              cfg_dir_in,
    input  logic              cfg_strobe_hi,
    input  logic [GAP_W-1:0]  cfg_gap_units,
    input  logic              cfg_count_en,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              ctl_go,
    input  logic              ctl_stop,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic [DATA_W-1:0] fifo_wdata,
    input  logic              dma_ack,
    input  logic              dma_wr_strb,
    input  logic              dma_rd_strb,
    input  logic [DATA_W-1:0] dma_din,
    output logic [DATA_W-1:0] dma_dout,
    output logic              dma_dout_en,
    output logic              dma_req,
    output logic              dma_req_n,
    output logic              xfer_running,
    output logic              xfer_done
);
    localparam int N_PATHS = 2;

    port_cfg_t cfg;
    assign cfg.single    = cfg_single;
    assign cfg.path      = cfg_dir_in ? PATH_WRITE : PATH_READ;
    assign cfg.strobe_hi = cfg_strobe_hi;
    assign cfg.count_en  = cfg_count_en;

    logic running_q, done_q, req_q, cnt_mode_q;
    logic gap_hold, cnt_last;

    // One edge detector per strobe; index follows path_e encoding.
    logic [N_PATHS-1:0] strb_raw;
    logic [N_PATHS-1:0] strb_fire;
    assign strb_raw[PATH_READ]  = dma_rd_strb;
    assign strb_raw[PATH_WRITE] = dma_wr_strb;

    generate
        for (genvar p = 0; p < N_PATHS; p++) begin : g_edge
            swdma_strobe_edge u_edge (
                .clk  (clk),
                .rst  (rst),
                .raw  (strb_raw[p]),
                .hi   (cfg.strobe_hi),
                .fire (strb_fire[p])
            );
        end
    endgenerate

    logic fire, avail, accept, start, go_empty, finish, req_next;

    assign fire     = strb_fire[cfg.path];
    assign avail    = fifo_can_serve(cfg.path, fifo_full, fifo_empty);
    assign accept   = running_q & req_q & fire & ~ctl_stop;
    assign start    = ctl_go & cfg.single & ~ctl_stop;
    assign go_empty = cfg.count_en & (cfg_count == '0);
    assign finish   = accept & cnt_mode_q & cnt_last;
    assign req_next = running_q & avail & ~gap_hold & ~accept & ~ctl_stop;

    swdma_gap_timer #(
        .UNIT_CYCLES (UNIT_CYCLES),
        .GAP_W       (GAP_W)
    ) u_gap (
        .clk       (clk),
        .rst       (rst),
        .clear     (start | ctl_stop),
        .byte_done (accept),
        .gap_units (cfg_gap_units),
        .hold      (gap_hold)
    );

    swdma_byte_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (cfg_count),
        .dec      (accept & cnt_mode_q),
        .last     (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q  <= 1'b0;
            done_q     <= 1'b0;
            req_q      <= 1'b0;
            cnt_mode_q <= 1'b0;
        end else begin
            if (ctl_stop) begin
                running_q <= 1'b0;
                done_q    <= 1'b1;
            end else if (start) begin
                running_q  <= ~go_empty;
                done_q     <= go_empty;
                cnt_mode_q <= cfg.count_en;
            end else if (finish) begin
                running_q <= 1'b0;
                done_q    <= 1'b1;
            end
            req_q <= req_next;
        end
    end

    assign fifo_push    = accept & (cfg.path == PATH_WRITE);
    assign fifo_pop     = accept & (cfg.path == PATH_READ);
    assign fifo_wdata   = dma_din;
    assign dma_dout     = fifo_rdata;
    assign dma_dout_en  = running_q & (cfg.path == PATH_READ) & dma_ack;
    assign dma_req      = req_q;
    assign dma_req_n    = ~req_q;
    assign xfer_running = running_q;
    assign xfer_done    = done_q;

    // R3: a request only exists inside a running transfer
    assert_req_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> xfer_running);

    // R5: the request is down the cycle after a completed byte
    assert_drop_after_byte_R5: assert property (@(posedge clk) disable iff (rst)
        (fifo_push || fifo_pop) |=> !dma_req);

    // R7: the request stays low throughout a hold-off
    assert_gap_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        gap_hold |-> !dma_req);

    // R9: stop ends the transfer at the next edge
    assert_stop_ends_R9: assert property (@(posedge clk) disable iff (rst)
        ctl_stop |=> (!xfer_running && xfer_done && !dma_req));

    // R11: FIFO is only touched under an outstanding request
    assert_no_idle_access_R11: assert property (@(posedge clk) disable iff (rst)
        (fifo_push || fifo_pop) |-> (dma_req && xfer_running));

    // R6: read data is offered only under acknowledge
    assert_dout_needs_ack_R6: assert property (@(posedge clk) disable iff (rst)
        dma_dout_en |-> dma_ack);

    // R2: Go is ignored outside single-word mode
    assert_go_blocked_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_go && !cfg_single && !xfer_running) |=> !xfer_running);

    // R10: a starting Go with a nonzero budget clears done
    assert_done_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !go_empty) |=> !xfer_done);
endmodule

// File: tb/swdma_port_tb_top.sv
module swdma_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 4;
    localparam int DEPTH      = 8;
    localparam int NVEC       = 13;

    // {dir_in, strobe_hi, gap[3:0], data[7:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 4'd2, 8'hA1}, {1'b1, 1'b1, 4'd2, 8'h12},
        {1'b1, 1'b1, 4'd2, 8'h3C}, {1'b1, 1'b1, 4'd2, 8'hF0},
        {1'b1, 1'b1, 4'd2, 8'h5A}, {1'b1, 1'b1, 4'd2, 8'h07},
        {1'b1, 1'b0, 4'd0, 8'h81}, {1'b1, 1'b0, 4'd0, 8'h42},
        {1'b1, 1'b0, 4'd0, 8'hC3}, {1'b1, 1'b0, 4'd0, 8'h24},
        {1'b0, 1'b1, 4'd1, 8'h99}, {1'b0, 1'b1, 4'd1, 8'h6E},
        {1'b0, 1'b1, 4'd1, 8'hD2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        cfg_single = 1'b0, cfg_dir_in = 1'b0, cfg_strobe_hi = 1'b1, cfg_count_en = 1'b0;
    logic [3:0]  cfg_gap_units = '0;
    logic [31:0] cfg_count = '0;
    logic        ctl_go = 1'b0, ctl_stop = 1'b0;
    logic        fifo_full, fifo_empty, fifo_push, fifo_pop;
    logic [7:0]  fifo_rdata, fifo_wdata, dma_dout;
    logic        dma_ack = 1'b0, dma_wr_strb = 1'b0, dma_rd_strb = 1'b0;
    logic [7:0]  dma_din = '0;
    logic        dma_dout_en, dma_req, dma_req_n, xfer_running, xfer_done;

    swdma_port #(.UNIT_CYCLES(UNIT), .GAP_W(4), .CNT_W(32), .DATA_W(8)) dut_i (
        .clk(clk), .rst(rst), .cfg_single(cfg_single), .cfg_dir_in(cfg_dir_in),
        .cfg_strobe_hi(cfg_strobe_hi), .cfg_gap_units(cfg_gap_units),
        .cfg_count_en(cfg_count_en), .cfg_count(cfg_count), .ctl_go(ctl_go),
        .ctl_stop(ctl_stop), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .fifo_rdata(fifo_rdata), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
        .fifo_wdata(fifo_wdata), .dma_ack(dma_ack), .dma_wr_strb(dma_wr_strb),
        .dma_rd_strb(dma_rd_strb), .dma_din(dma_din), .dma_dout(dma_dout),
        .dma_dout_en(dma_dout_en), .dma_req(dma_req), .dma_req_n(dma_req_n),
        .xfer_running(xfer_running), .xfer_done(xfer_done)
    );

    // Behavioural endpoint FIFO
    logic [7:0] mem [DEPTH];
    int wp = 0, rp = 0, cnt = 0, push_count = 0, pop_count = 0;
    logic [7:0] last_wr = '0;
    logic tb_push = 1'b0, tb_flush = 1'b0;
    logic [7:0] tb_data = '0;
    logic do_push, do_pop;

    assign do_push    = (fifo_push || tb_push) && (cnt < DEPTH);
    assign do_pop     = fifo_pop && (cnt > 0);
    assign fifo_full  = (cnt == DEPTH);
    assign fifo_empty = (cnt == 0);
    assign fifo_rdata = mem[rp];

    always @(posedge clk) begin
        if (tb_flush) begin
            wp <= 0; rp <= 0; cnt <= 0;
        end else begin
            if (do_push) begin
                mem[wp] <= fifo_push ? fifo_wdata : tb_data;
                wp <= (wp + 1) % DEPTH;
            end
            if (do_pop) rp <= (rp + 1) % DEPTH;
            cnt <= cnt + int'(do_push) - int'(do_pop);
        end
        if (fifo_push) begin
            push_count <= push_count + 1;
            last_wr    <= fifo_wdata;
        end
        if (fifo_pop) pop_count <= pop_count + 1;
    end

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_run(input logic dir_in, input logic lvl, input logic [3:0] gap,
                             input logic cen, input int cval);
        @(negedge clk); ctl_stop = 1'b1; tb_flush = 1'b1;
        @(negedge clk); ctl_stop = 1'b0; tb_flush = 1'b0;
        cfg_single = 1'b1; cfg_dir_in = dir_in; cfg_strobe_hi = lvl;
        cfg_gap_units = gap; cfg_count_en = cen; cfg_count = 32'(cval);
        dma_wr_strb = ~lvl; dma_rd_strb = ~lvl; dma_ack = 1'b0;
        @(negedge clk); ctl_go = 1'b1;
        @(negedge clk); ctl_go = 1'b0;
    endtask

    task automatic wait_req(output int lat);
        lat = 0;
        while (!dma_req && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        if (!dma_req) lat = -1;
    endtask

    task automatic write_byte(input logic [7:0] d);
        dma_din = d; dma_wr_strb = cfg_strobe_hi;
        @(negedge clk);
        dma_wr_strb = ~cfg_strobe_hi;
    endtask

    task automatic read_byte(output logic [7:0] d, output logic en);
        dma_ack = 1'b1; dma_rd_strb = cfg_strobe_hi;
        #1; d = dma_dout; en = dma_dout_en;
        @(negedge clk);
        dma_rd_strb = ~cfg_strobe_hi; dma_ack = 1'b0;
    endtask

    task automatic load_fifo(input logic [7:0] d);
        @(negedge clk); tb_push = 1'b1; tb_data = d;
        @(negedge clk); tb_push = 1'b0;
    endtask

    initial begin
        int lat, pc, exp_lat, pos, c0;
        logic [13:0] prev;
        logic [7:0] rd;
        logic en;

        // R1 reset state
        repeat (3) @(negedge clk);
        check_eq("R1 req in reset", int'(dma_req), 0);
        check_eq("R1 req_n in reset", int'(dma_req_n), 1);
        check_eq("R1 running in reset", int'(xfer_running), 0);
        check_eq("R1 done in reset", int'(xfer_done), 0);
        check_eq("R1 dout_en in reset", int'(dma_dout_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 req after reset", int'(dma_req), 0);

        // R2 Go outside single-word mode
        cfg_single = 1'b0; cfg_dir_in = 1'b1; ctl_go = 1'b1;
        @(negedge clk); ctl_go = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R2 running without single mode", int'(xfer_running), 0);
        check_eq("R2 req without single mode", int'(dma_req), 0);

        // Vector table walk
        pos = 0; prev = '0;
        for (int i = 0; i < NVEC; i++) begin
            if (i == 0 || VEC[i][13:8] != prev[13:8]) begin
                start_run(VEC[i][13], VEC[i][12], VEC[i][11:8], 1'b0, 0);
                pos = 0;
            end
            prev = VEC[i];
            if (VEC[i][13]) begin
                wait_req(lat);
                check_eq("R3 request with room", int'(dma_req), 1);
                pc = push_count;
                write_byte(VEC[i][7:0]);
                check_eq("R4 one push per strobe edge", push_count, pc + 1);
                check_eq("R4 captured byte", int'(last_wr), int'(VEC[i][7:0]));
                wait_req(lat);
                exp_lat = (pos % 4 == 3 && VEC[i][11:8] != 0) ? 1 + int'(VEC[i][11:8]) * UNIT : 1;
                if (pos % 4 == 3) check_eq("R7 request gap after fourth byte", lat, exp_lat);
                else              check_eq("R5 single-cycle request drop", lat, exp_lat);
            end else begin
                load_fifo(VEC[i][7:0]);
                wait_req(lat);
                check_eq("R3 request with data", int'(dma_req), 1);
                pc = pop_count;
                read_byte(rd, en);
                check_eq("R6 read data", int'(rd), int'(VEC[i][7:0]));
                check_eq("R6 dout enable under ack", int'(en), 1);
                check_eq("R4 one pop per strobe edge", pop_count, pc + 1);
            end
            pos++;
        end

        // R3 / R11: full FIFO refuses
        start_run(1'b1, 1'b1, 4'd0, 1'b0, 0);
        @(negedge clk); tb_push = 1'b1; tb_data = 8'h11;
        repeat (DEPTH) @(negedge clk);
        tb_push = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R3 no request when full", int'(dma_req), 0);
        check_eq("R3 req_n when full", int'(dma_req_n), 1);
        pc = push_count; c0 = cnt;
        write_byte(8'h55);
        @(negedge clk);
        check_eq("R11 strobe without request ignored", push_count, pc);
        check_eq("R11 fifo level unchanged", cnt, c0);

        // R3 read path empty, R6 ack gating
        start_run(1'b0, 1'b1, 4'd0, 1'b0, 0);
        repeat (4) @(negedge clk);
        check_eq("R3 no request when empty", int'(dma_req), 0);
        check_eq("R6 dout_en without ack", int'(dma_dout_en), 0);
        dma_ack = 1'b1; #1;
        check_eq("R6 dout_en with ack", int'(dma_dout_en), 1);
        dma_ack = 1'b0;

        // R8 zero count
        start_run(1'b1, 1'b1, 4'd0, 1'b1, 0);
        repeat (3) @(negedge clk);
        check_eq("R8 zero count not running", int'(xfer_running), 0);
        check_eq("R8 zero count done", int'(xfer_done), 1);
        check_eq("R8 zero count no request", int'(dma_req), 0);

        // R8 countdown of three bytes, R10 done cleared
        start_run(1'b1, 1'b1, 4'd0, 1'b1, 3);
        check_eq("R10 done cleared by Go", int'(xfer_done), 0);
        pc = push_count;
        for (int k = 0; k < 3; k++) begin
            wait_req(lat);
            write_byte(8'(8'h30 + k));
        end
        check_eq("R8 bytes moved", push_count, pc + 3);
        check_eq("R8 running cleared at count end", int'(xfer_running), 0);
        check_eq("R8 done at count end", int'(xfer_done), 1);
        repeat (2) @(negedge clk);
        check_eq("R8 no request after count end", int'(dma_req), 0);

        // R9 stop collides with a strobe edge
        start_run(1'b1, 1'b1, 4'd0, 1'b0, 0);
        wait_req(lat);
        check_eq("R9 request before stop", int'(dma_req), 1);
        pc = push_count;
        ctl_stop = 1'b1; dma_din = 8'h77; dma_wr_strb = 1'b1;
        @(negedge clk);
        ctl_stop = 1'b0; dma_wr_strb = 1'b0;
        check_eq("R9 byte discarded on stop", push_count, pc);
        check_eq("R9 running cleared", int'(xfer_running), 0);
        check_eq("R9 done set", int'(xfer_done), 1);
        check_eq("R9 request cleared", int'(dma_req), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule